// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside the fetch logic of an 8-bit processor and decides, at each instruction boundary, whether an interrupt or reset entry runs instead of the next opcode fetch. It watches two active-low lines, `nmi_n` and `irq_n`. The non-maskable line is edge-triggered and the maskable line is level-triggered. It also takes a software-break request from the execution logic and a reset request, and picks the winner by priority. The chosen entry then runs on a byte bus with a request/acknowledge handshake: two dummy reads, three stack pushes and a two-byte vector fetch. At the end the block hands the new program counter and stack pointer back, together with a one-cycle completion pulse.

A free-running cycle count comes in on `cycle_cnt`. When a line falls, the block stores that count plus a fixed delay, and the line may not be honoured before the count reaches the stored value. The execution core owns the status byte. This block reads the status byte, and it reports which flag update the core must apply when the entry completes: set interrupt-disable after an interrupt, or clear all flags after a reset.

The control is one state machine with the states IDLE, DUM0 (dummy read at PC), DUM1 (dummy read at PC+1), PSH_H (push PC high), PSH_L (push PC low), PSH_P (push status), VEC_L (vector low byte) and VEC_H (vector high byte). The transitions are as follows. IDLE goes to DUM0 when an interrupt or break starts, and to VEC_L when a reset starts. Each bus state moves to the next state in the list above only in a cycle where `bus_ack` is high. PSH_P goes to VEC_L, and VEC_H returns to IDLE.

Top module: `intr_entry_seq`

## Requirements
- R1: After a high-to-low change of `nmi_n` or `irq_n` is sampled at a clock edge where `cycle_cnt` equals C, that line cannot start an entry at any edge where `cycle_cnt` is below C+2. With a count that rises by one each cycle and `boundary` held high, `busy` first reads high after the third rising edge that sees the line low.
- R2: The non-maskable line is serviced once per falling edge. While it stays low after its service, it starts no further entry. After it returns high and falls again, it is serviced again.
- R3: Priority is reset, then the non-maskable line, then the maskable line or a break. The maskable line and a break start an entry only when bit 2 of `status_in` (interrupt disable) is 0. The non-maskable line ignores that bit. A break seen while masked is dropped.
- R4: A maskable request that arrives while bit 2 is 1 stays pending as long as `irq_n` is held low, and it is serviced once bit 2 reads 0 at a boundary.
- R5: An interrupt or break entry makes exactly these bus transfers, in this order: read at PC, read at PC+1, write of the saved PC high byte, write of the saved PC low byte, write of the status, read at the vector address, read at the vector address plus one.
- R6: The pushed status is `status_in` with bit 5 forced to 1. Bit 4 is 1 for a break and 0 for the non-maskable or maskable line. For a break the saved PC is PC+1; otherwise it is PC.
- R7: The vector pairs are at 0xFFFA/0xFFFB for the non-maskable line, 0xFFFE/0xFFFF for the maskable line and for break, and 0xFFFC/0xFFFD for reset. The low byte comes first, and `pc_out` = {second byte, first byte}.
- R8: Each push writes to address 0x0100 plus the current stack pointer and then decrements the stack pointer modulo 256. After an interrupt entry `sp_out` = `sp_in` − 3 (mod 256).
- R9: A reset entry makes only the two vector reads and no pushes. It leaves `sp_out` = `sp_in` and raises `clr_all` with `done`. It discards the armed state of both lines, so a line that is held low needs a fresh falling edge before it can be serviced.
- R10: After reset `busy`, `done` and `bus_req` are low. `done` is high for exactly one cycle, the cycle after the vector-high transfer, and `busy` is low in that cycle. `set_i` accompanies `done` for interrupt and break entries.
- R11: While `bus_req` is high and `bus_ack` is low, the address, direction and write data hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cycle_cnt | input | 32 | Free-running cycle count |
| nmi_n | input | 1 | Non-maskable interrupt line, active low, edge-triggered |
| irq_n | input | 1 | Maskable interrupt line, active low, level-triggered |
| reset_req | input | 1 | One-cycle pulse requesting a reset entry |
| brk_req | input | 1 | Software break request, valid with `boundary` |
| boundary | input | 1 | Instruction boundary: an entry may start |
| status_in | input | 8 | Current status byte; bit 2 is interrupt disable |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 8 | Current stack pointer |
| bus_req | output | 1 | Bus transfer requested |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Transfer address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transfer completes at this edge |
| busy | output | 1 | An entry is in progress; fetch must stall |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | New program counter, valid from `done` |
| sp_out | output | 8 | New stack pointer, valid from `done` |
| set_i | output | 1 | With `done`: set interrupt disable |
| clr_all | output | 1 | With `done`: clear all flags (reset entry) |

## Verification
A wrong arming or service record in a line watcher shows up as an entry that is missing or repeated. The first bus read of a spurious entry appears within one cycle of an idle boundary, or within three cycles of a falling line. A wrong priority or vector selection shows up at the vector-read address. A wrong stack-pointer or status latch shows up at the three push writes, well before `done`. A miscount in the state machine shows up as a transfer that arrives out of order or unexpected on the bus.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DUM0,
        S_DUM1,
        S_PSH_H,
        S_PSH_L,
        S_PSH_P,
        S_VEC_L,
        S_VEC_H
    } seq_state_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_RESET,
        K_NMI,
        K_IRQ,
        K_BRK
    } cause_t;

    localparam int unsigned STAT_W   = 8;
    localparam int unsigned IDIS_BIT = 2;
    localparam int unsigned BRKF_BIT = 4;
    localparam int unsigned ONE_BIT  = 5;

endpackage

// File: rtl/line_watch.sv
module line_watch #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned DELAY = 2,
    parameter bit          EDGE  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_n,
    input  logic             flush,
    input  logic             svc,
    input  logic [CNT_W-1:0] cycle_cnt,
    output logic             req
);

    logic             prev_n;
    logic             armed;
    logic [CNT_W-1:0] stamp;
    logic [CNT_W-1:0] age;
    logic             fall;
    logic             ripe;
    logic             consume;

    assign fall    = prev_n & ~line_n;
    assign age     = cycle_cnt - stamp;
    assign ripe    = ~age[CNT_W-1];
    assign consume = EDGE ? svc : 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_n <= 1'b1;
            armed  <= 1'b0;
            stamp  <= '0;
        end else begin
            prev_n <= line_n;
            if (fall)
                stamp <= cycle_cnt + CNT_W'(DELAY);
            if (flush || line_n)
                armed <= 1'b0;
            else if (fall)
                armed <= 1'b1;
            else if (consume)
                armed <= 1'b0;
        end
    end

    assign req = armed & ~line_n & ripe;

    // R1
    fresh_fall_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !req);

    generate
        if (EDGE) begin : g_edge_chk
            // R2
            one_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
                svc |=> !req);
        end
    endgenerate

endmodule

// File: rtl/cause_pick.sv
module cause_pick
    import intr_seq_pkg::*;
(
    input  logic   rst_pend,
    input  logic   nmi_req,
    input  logic   irq_req,
    input  logic   brk_req,
    input  logic   masked,
    output cause_t cause
);

    always_comb begin
        cause = K_NONE;
        if (rst_pend)
            cause = K_RESET;
        else if (nmi_req)
            cause = K_NMI;
        else if (!masked && brk_req)
            cause = K_BRK;
        else if (!masked && irq_req)
            cause = K_IRQ;
    end

endmodule

// File: rtl/entry_fsm.sv
module entry_fsm
    import intr_seq_pkg::*;
#(
    parameter logic [15:0] NMI_VEC    = 16'hFFFA,
    parameter logic [15:0] RST_VEC    = 16'hFFFC,
    parameter logic [15:0] IRQ_VEC    = 16'hFFFE,
    parameter logic [7:0]  STACK_PAGE = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cause_t            start_cause,
    input  logic [15:0]       pc_in,
    input  logic [7:0]        sp_in,
    input  logic [STAT_W-1:0] status_in,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [15:0]       bus_addr,
    output logic [7:0]        bus_wdata,
    output logic              busy,
    output logic              done,
    output logic [15:0]       pc_out,
    output logic [7:0]        sp_out,
    output logic              set_i,
    output logic              clr_all
);

    seq_state_t        state, state_d;
    cause_t            cause_q;
    logic [15:0]       pc_raw;
    logic [STAT_W-1:0] stat_q;
    logic [7:0]        sp_q;
    logic [7:0]        vec_lo;
    logic [15:0]       push_pc;
    logic [15:0]       vec_base;
    logic              is_brk_start;

    assign is_brk_start = (start_cause == K_BRK);
    assign push_pc      = pc_raw + ((cause_q == K_BRK) ? 16'd1 : 16'd0);

    always_comb begin
        unique case (cause_q)
            K_RESET: vec_base = RST_VEC;
            K_NMI:   vec_base = NMI_VEC;
            default: vec_base = IRQ_VEC;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE:  if (start) state_d = (start_cause == K_RESET) ? S_VEC_L : S_DUM0;
            S_DUM0:  if (bus_ack) state_d = S_DUM1;
            S_DUM1:  if (bus_ack) state_d = S_PSH_H;
            S_PSH_H: if (bus_ack) state_d = S_PSH_L;
            S_PSH_L: if (bus_ack) state_d = S_PSH_P;
            S_PSH_P: if (bus_ack) state_d = S_VEC_L;
            S_VEC_L: if (bus_ack) state_d = S_VEC_H;
            S_VEC_H: if (bus_ack) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= K_NONE;
            pc_raw  <= '0;
            stat_q  <= '0;
            sp_q    <= '0;
            vec_lo  <= '0;
            pc_out  <= '0;
            done    <= 1'b0;
            set_i   <= 1'b0;
            clr_all <= 1'b0;
        end else begin
            done    <= 1'b0;
            set_i   <= 1'b0;
            clr_all <= 1'b0;
            if (state == S_IDLE && start) begin
                cause_q <= start_cause;
                pc_raw  <= pc_in;
                sp_q    <= sp_in;
                stat_q  <= status_in;
                stat_q[ONE_BIT]  <= 1'b1;
                stat_q[BRKF_BIT] <= is_brk_start;
            end
            if (bus_ack && (state == S_PSH_H || state == S_PSH_L || state == S_PSH_P))
                sp_q <= sp_q - 8'd1;
            if (bus_ack && state == S_VEC_L)
                vec_lo <= bus_rdata;
            if (bus_ack && state == S_VEC_H) begin
                pc_out  <= {bus_rdata, vec_lo};
                done    <= 1'b1;
                set_i   <= (cause_q != K_RESET);
                clr_all <= (cause_q == K_RESET);
            end
        end
    end

    // outputs
    always_comb begin
        bus_req   = 1'b1;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            S_IDLE:  bus_req = 1'b0;
            S_DUM0:  bus_addr = pc_raw;
            S_DUM1:  bus_addr = pc_raw + 16'd1;
            S_PSH_H: begin
                bus_we    = 1'b1;
                bus_addr  = {STACK_PAGE, sp_q};
                bus_wdata = push_pc[15:8];
            end
            S_PSH_L: begin
                bus_we    = 1'b1;
                bus_addr  = {STACK_PAGE, sp_q};
                bus_wdata = push_pc[7:0];
            end
            S_PSH_P: begin
                bus_we    = 1'b1;
                bus_addr  = {STACK_PAGE, sp_q};
                bus_wdata = stat_q;
            end
            S_VEC_L: bus_addr = vec_base;
            S_VEC_H: bus_addr = vec_base + 16'd1;
            default: bus_req = 1'b0;
        endcase
    end

    assign busy   = (state != S_IDLE);
    assign sp_out = sp_q;

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R8
    push_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> (bus_addr[15:8] == STACK_PAGE));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_seq_pkg::*;
#(
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned DELAY      = 2,
    parameter logic [15:0] NMI_VEC    = 16'hFFFA,
    parameter logic [15:0] RST_VEC    = 16'hFFFC,
    parameter logic [15:0] IRQ_VEC    = 16'hFFFE,
    parameter logic [7:0]  STACK_PAGE = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cycle_cnt,
    input  logic             nmi_n,
    input  logic             irq_n,
    input  logic             reset_req,
    input  logic             brk_req,
    input  logic             boundary,
    input  logic [7:0]       status_in,
    input  logic [15:0]      pc_in,
    input  logic [7:0]       sp_in,
    output logic             bus_req,
    output logic             bus_we,
    output logic [15:0]      bus_addr,
    output logic [7:0]       bus_wdata,
    input  logic [7:0]       bus_rdata,
    input  logic             bus_ack,
    output logic             busy,
    output logic             done,
    output logic [15:0]      pc_out,
    output logic [7:0]       sp_out,
    output logic             set_i,
    output logic             clr_all
);

    logic   rst_pend;
    logic   nmi_req, irq_req;
    logic   start, flush, nmi_svc;
    cause_t cause;

    line_watch #(.CNT_W(CNT_W), .DELAY(DELAY), .EDGE(1'b1)) u_nmi (
        .clk(clk), .rst_n(rst_n), .line_n(nmi_n), .flush(flush),
        .svc(nmi_svc), .cycle_cnt(cycle_cnt), .req(nmi_req)
    );

    line_watch #(.CNT_W(CNT_W), .DELAY(DELAY), .EDGE(1'b0)) u_irq (
        .clk(clk), .rst_n(rst_n), .line_n(irq_n), .flush(flush),
        .svc(1'b0), .cycle_cnt(cycle_cnt), .req(irq_req)
    );

    cause_pick u_pick (
        .rst_pend(rst_pend), .nmi_req(nmi_req), .irq_req(irq_req),
        .brk_req(brk_req & boundary), .masked(status_in[IDIS_BIT]), .cause(cause)
    );

    assign start   = !busy && ((cause == K_RESET) || (boundary && cause != K_NONE));
    assign flush   = start && (cause == K_RESET);
    assign nmi_svc = start && (cause == K_NMI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rst_pend <= 1'b0;
        else if (reset_req)
            rst_pend <= 1'b1;
        else if (flush)
            rst_pend <= 1'b0;
    end

    entry_fsm #(
        .NMI_VEC(NMI_VEC), .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC), .STACK_PAGE(STACK_PAGE)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .start_cause(cause),
        .pc_in(pc_in), .sp_in(sp_in), .status_in(status_in),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out),
        .set_i(set_i), .clr_all(clr_all)
    );

    // R3
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (cause == K_IRQ || cause == K_BRK)) |-> !status_in[IDIS_BIT]);

endmodule

// File: tb/sim_intr_entry_seq.sv
`timescale 1ns/1ps
module sim_intr_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cyc = '0;
    logic        nmi_n, irq_n, reset_req, brk_req, boundary;
    logic [7:0]  status_in, sp_in;
    logic [15:0] pc_in;
    logic        bus_req, bus_we, bus_ack, busy, done, set_i, clr_all;
    logic [15:0] bus_addr, pc_out;
    logic [7:0]  bus_wdata, bus_rdata, sp_out;
    logic        ack_en, stall_mode;

    int nchk = 0;
    int nfail = 0;

    logic [24:0] bq[$];
    string       btag[$];
    logic [25:0] dq[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 32'd1;
    always @(posedge clk) ack_en <= stall_mode ? ~ack_en : 1'b1;

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        case (a)
            16'hFFFA: mem_rd = 8'h34;
            16'hFFFB: mem_rd = 8'h12;
            16'hFFFC: mem_rd = 8'hBC;
            16'hFFFD: mem_rd = 8'h9A;
            16'hFFFE: mem_rd = 8'h78;
            16'hFFFF: mem_rd = 8'h56;
            default:  mem_rd = a[7:0] ^ 8'h5A;
        endcase
    endfunction

    assign bus_ack   = bus_req & ack_en;
    assign bus_rdata = mem_rd(bus_addr);

    intr_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .cycle_cnt(cyc), .nmi_n(nmi_n), .irq_n(irq_n),
        .reset_req(reset_req), .brk_req(brk_req), .boundary(boundary),
        .status_in(status_in), .pc_in(pc_in), .sp_in(sp_in),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .busy(busy), .done(done),
        .pc_out(pc_out), .sp_out(sp_out), .set_i(set_i), .clr_all(clr_all)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    // driver side: expected transfers and completions
    task automatic exp_bus(input bit we, input logic [15:0] a, input logic [7:0] d, input string tag);
        bq.push_back({we, a, d});
        btag.push_back(tag);
    endtask

    // kind: 0 = nmi, 1 = irq, 2 = brk
    task automatic exp_entry(input logic [15:0] pc, input logic [7:0] sp,
                             input logic [7:0] st, input int kind);
        logic [15:0] pp, vb, np;
        logic [7:0]  ps;
        pp = pc + ((kind == 2) ? 16'd1 : 16'd0);
        ps = st | 8'h20;
        ps[4] = (kind == 2);
        vb = (kind == 0) ? 16'hFFFA : 16'hFFFE;
        np = (kind == 0) ? 16'h1234 : 16'h5678;
        exp_bus(1'b0, pc, 8'h00, "R5");
        exp_bus(1'b0, pc + 16'd1, 8'h00, "R5");
        exp_bus(1'b1, {8'h01, sp}, pp[15:8], "R8");
        exp_bus(1'b1, {8'h01, sp - 8'd1}, pp[7:0], "R6");
        exp_bus(1'b1, {8'h01, sp - 8'd2}, ps, "R6");
        exp_bus(1'b0, vb, 8'h00, "R7");
        exp_bus(1'b0, vb + 16'd1, 8'h00, "R7");
        dq.push_back({np, sp - 8'd3, 1'b1, 1'b0});
    endtask

    task automatic exp_reset(input logic [7:0] sp);
        exp_bus(1'b0, 16'hFFFC, 8'h00, "R9");
        exp_bus(1'b0, 16'hFFFD, 8'h00, "R9");
        dq.push_back({16'h9ABC, sp, 1'b0, 1'b1});
    endtask

    task automatic wait_done(input string req);
        bit fin;
        fin = 1'b0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (!busy && bq.size() == 0 && dq.size() == 0) begin
                fin = 1'b1;
                break;
            end
        end
        chk(fin, req, "entry completion", {31'd0, fin}, 32'd1);
        tick;
    endtask

    task automatic kick(input string req);
        bit seen;
        seen = 1'b0;
        boundary = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (busy) begin
                seen = 1'b1;
                break;
            end
        end
        chk(seen, req, "entry start", {31'd0, seen}, 32'd1);
        tick;
        boundary = 1'b0;
        brk_req  = 1'b0;
    endtask

    task automatic idle_check(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!busy && !bus_req, req, "no entry expected", {31'd0, busy}, 32'd0);
        end
        tick;
    endtask

    // monitor side: pop and compare
    logic        hold_v = 1'b0;
    logic [16:0] hold_a;
    logic [7:0]  hold_d;
    logic        done_prev = 1'b0;

    always @(negedge clk) begin
        logic [24:0] it;
        logic [25:0] di;
        string       tg;
        if (rst_n) begin
            if (hold_v)
                chk(bus_req && {bus_we, bus_addr} == hold_a && bus_wdata == hold_d,
                    "R11", "stalled transfer held", {15'd0, bus_we, bus_addr}, {15'd0, hold_a});
            hold_v = bus_req && !bus_ack;
            hold_a = {bus_we, bus_addr};
            hold_d = bus_wdata;
            if (bus_req && bus_ack) begin
                if (bq.size() == 0) begin
                    chk(1'b0, "R5", "unexpected transfer", {15'd0, bus_we, bus_addr}, 32'd0);
                end else begin
                    it = bq.pop_front();
                    tg = btag.pop_front();
                    chk(bus_we == it[24] && bus_addr == it[23:8], "R5", "transfer kind/address",
                        {15'd0, bus_we, bus_addr}, {15'd0, it[24:8]});
                    if (it[24])
                        chk(bus_wdata == it[7:0], tg, "write data", {24'd0, bus_wdata}, {24'd0, it[7:0]});
                end
            end
            if (done) begin
                chk(!busy, "R10", "busy low with done", {31'd0, busy}, 32'd0);
                if (dq.size() == 0) begin
                    chk(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
                end else begin
                    di = dq.pop_front();
                    chk(pc_out == di[25:10], "R7", "pc_out", {16'd0, pc_out}, {16'd0, di[25:10]});
                    chk(sp_out == di[9:2], "R8", "sp_out", {24'd0, sp_out}, {24'd0, di[9:2]});
                    chk({set_i, clr_all} == di[1:0], "R10", "set_i/clr_all",
                        {30'd0, set_i, clr_all}, {30'd0, di[1:0]});
                end
            end
            if (done && done_prev)
                chk(1'b0, "R10", "done wider than one cycle", 32'd2, 32'd1);
            done_prev = done;
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n = 1'b0; nmi_n = 1'b1; irq_n = 1'b1; reset_req = 1'b0; brk_req = 1'b0;
        boundary = 1'b0; status_in = 8'h00; pc_in = 16'h0000; sp_in = 8'hFF;
        stall_mode = 1'b0;
        repeat (3) tick;
        @(negedge clk);
        chk(!busy && !done && !bus_req, "R10", "reset state", {29'd0, busy, done, bus_req}, 32'd0);
        tick;
        rst_n = 1'b1;
        tick;

        // R9 reset entry
        exp_reset(8'hFF);
        reset_req = 1'b1;
        tick;
        reset_req = 1'b0;
        wait_done("R9");

        // R1 timing on a maskable entry
        status_in = 8'h00; pc_in = 16'h4000; sp_in = 8'hFD;
        exp_entry(16'h4000, 8'hFD, 8'h00, 1);
        boundary = 1'b1;
        tick;
        irq_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!busy, "R1", "busy one edge after fall", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk(!busy, "R1", "busy two edges after fall", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk(busy, "R1", "busy three edges after fall", {31'd0, busy}, 32'd1);
        tick;
        boundary = 1'b0;
        wait_done("R1");
        irq_n = 1'b1;
        tick;

        // R4 masked request stays pending
        status_in = 8'h04; pc_in = 16'h4100; sp_in = 8'hFA;
        irq_n = 1'b0;
        boundary = 1'b1;
        idle_check(8, "R4");
        exp_entry(16'h4100, 8'hFA, 8'h00, 1);
        status_in = 8'h00;
        kick("R4");
        wait_done("R4");
        irq_n = 1'b1;
        tick;

        // R3 priority: non-maskable over maskable
        pc_in = 16'h5000; sp_in = 8'hF7;
        exp_entry(16'h5000, 8'hF7, 8'h00, 0);
        nmi_n = 1'b0; irq_n = 1'b0;
        tick;
        kick("R3");
        wait_done("R3");

        // R2 held low: no second service
        status_in = 8'h04;
        boundary = 1'b1;
        idle_check(8, "R2");
        boundary = 1'b0;
        nmi_n = 1'b1;
        tick; tick;
        nmi_n = 1'b0;
        pc_in = 16'h5100; sp_in = 8'hF4;
        exp_entry(16'h5100, 8'hF4, 8'h04, 0);
        kick("R2");
        wait_done("R2");
        nmi_n = 1'b1; irq_n = 1'b1;
        tick;

        // R6 break with stack wrap (R8) and stalls (R11)
        status_in = 8'hC3; pc_in = 16'h2222; sp_in = 8'h01;
        stall_mode = 1'b1;
        exp_entry(16'h2222, 8'h01, 8'hC3, 2);
        brk_req = 1'b1;
        kick("R6");
        wait_done("R6");
        stall_mode = 1'b0;
        tick;

        // R3 masked break dropped
        status_in = 8'h04;
        brk_req = 1'b1;
        boundary = 1'b1;
        idle_check(6, "R3");
        brk_req = 1'b0;
        boundary = 1'b0;
        tick;

        // R9 reset wins over armed lines, then flushes them
        status_in = 8'h00; sp_in = 8'h80; pc_in = 16'h6000;
        nmi_n = 1'b0; irq_n = 1'b0;
        repeat (4) tick;
        exp_reset(8'h80);
        reset_req = 1'b1;
        tick;
        reset_req = 1'b0;
        wait_done("R9");
        boundary = 1'b1;
        idle_check(8, "R9");
        boundary = 1'b0;
        irq_n = 1'b1;
        tick;
        irq_n = 1'b0;
        exp_entry(16'h6000, 8'h80, 8'h00, 1);
        kick("R9");
        wait_done("R9");
        nmi_n = 1'b1; irq_n = 1'b1;
        tick;

        chk(bq.size() == 0 && dq.size() == 0, "R5", "leftover expected items",
            bq.size() + dq.size(), 32'd0);
        summary();
    end

endmodule